// File: doc/BRIEF.md
# Unified Transform Input Sequencer

This block sets the order in which input samples reach the row adders of a prime-length array. The array computes a Fourier, Hartley, cosine or sine transform. One counter walks every (row, column) slot of the array. For each slot it produces the sample index (n·k) mod N. A step unit builds that index by adding k modulo N, so no multiplier is needed.

The only per-transform logic is a reordering of that index and a few routing flags:

- The cosine transform reads the folded sample order.
- The sine transform reads the sample one place above the cosine one.
- The Hartley mode feeds one sample into both adder inputs.
- The real Fourier mode forces zero onto the y input.
- The complex Fourier mode reads the paired imaginary FIFO at the same time as the real one.

A start request in idle latches the transform select and the complex flag. It then issues one sideband slot for the zero-index sample. After that it runs the (N−1)×(N−1) slot sweep and ends with a done pulse. N is an odd prime no larger than 11.

Top module: `xform_seq_top`

## Requirements
- R1: After reset, and whenever no sweep is active, valid_o, side_valid_o, done_o and every routing flag (x_en_o, y_en_o, y_zero_o, im_rd_o, mode_on_o) are 0.
- R2: A start_i sampled high in idle gives exactly one cycle with side_valid_o=1 and valid_o=0. side_idx_o is 1 for the sine transform and 0 for every other transform.
- R3: After the sideband cycle, one slot is issued per cycle with valid_o=1. row_o counts k from 1 to N−1 in the outer order and col_o counts n from 1 to N−1 in the inner order.
- R4: With xform_i=00 (Fourier) or 01 (Hartley), idx_o equals (row·col) mod N.
- R5: With xform_i=10 (cosine), let p=(row·col) mod N. Then idx_o is 2p when p ≤ (N−1)/2, and 2N−2p−1 otherwise.
- R6: With xform_i=11 (sine), idx_o is the R5 value plus one.
- R7: In Hartley mode, every slot has mode_on_o=1, x_en_o=1, y_en_o=1, y_zero_o=0 and im_rd_o=0, whatever cplx_i was.
- R8: In cosine and sine modes, every slot has x_en_o=1 and mode_on_o, y_en_o, y_zero_o and im_rd_o all 0, whatever cplx_i was.
- R9: In Fourier mode with cplx_i=0, every slot has y_zero_o=1 and y_en_o=im_rd_o=0. With cplx_i=1, y_en_o=im_rd_o=1 and y_zero_o=0. In both cases mode_on_o=0.
- R10: done_o is 1 only on the slot with row=col=N−1. The next cycle is idle.
- R11: start_i during a sweep is ignored. The transform and complex flag latched at the start hold for the whole sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sweep request, taken only in idle |
| xform_i | input | 2 | Transform select: 00 Fourier, 01 Hartley, 10 cosine, 11 sine |
| cplx_i | input | 1 | Complex input data (Fourier mode only) |
| valid_o | output | 1 | A permutation slot is issued this cycle |
| row_o | output | W | Row k of the current slot |
| col_o | output | W | Column n of the current slot |
| idx_o | output | W | Sample index to fetch for the slot |
| side_valid_o | output | 1 | Sideband slot for the zero-index sample |
| side_idx_o | output | W | Sample index on the sideband |
| x_en_o | output | 1 | Route the sample to the x adder |
| y_en_o | output | 1 | Route a sample to the y adder |
| y_zero_o | output | 1 | Force zero on the y adder input |
| im_rd_o | output | 1 | Read the paired imaginary FIFO |
| mode_on_o | output | 1 | Mode switch: one sample feeds both adders |
| done_o | output | 1 | Last slot of the sweep |

## Verification
Every output comes from registered state. A start request seen at one clock edge therefore shows the sideband slot after that edge. The first permutation slot appears one edge later, and each further slot one edge after that. The last slot, which carries done_o, comes (N−1)² edges after the sideband, and the idle state follows one edge later. The bench drives inputs and samples outputs on the falling edge. It reads the sideband on the first falling edge after the request and then one slot per falling edge. It computes the expected index by direct multiplication and modulo, not by accumulation.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
    typedef enum logic [1:0] {
        XF_DFT = 2'b00,
        XF_DHT = 2'b01,
        XF_DCT = 2'b10,
        XF_DST = 2'b11
    } xform_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_SIDE = 2'b01,
        PH_RUN  = 2'b10
    } phase_e;
endpackage

// File: rtl/xseq_modstep.sv
module xseq_modstep #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] inc_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] raw;

    always_comb begin
        raw = {1'b0, acc_i} + {1'b0, inc_i};
        if (raw >= (W+1)'(N)) begin
            sum_o = W'(raw - (W+1)'(N));
        end else begin
            sum_o = W'(raw);
        end
    end
endmodule

// File: rtl/xseq_idxmap.sv
module xseq_idxmap
    import xseq_pkg::*;
#(
    parameter int N = 5,
    parameter int W = 3
) (
    input  xform_e       xf_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] idx_o
);
    localparam int HALF = (N - 1) / 2;

    logic [W:0] folded;

    always_comb begin
        if (p_i <= W'(HALF)) begin
            folded = {p_i, 1'b0};
        end else begin
            folded = (W+1)'(2 * N - 1) - {p_i, 1'b0};
        end
        case (xf_i)
            XF_DCT:  idx_o = W'(folded);
            XF_DST:  idx_o = W'(folded + (W+1)'(1));
            default: idx_o = p_i;
        endcase
    end
endmodule

// File: rtl/xform_seq_top.sv
module xform_seq_top
    import xseq_pkg::*;
#(
    parameter int N = 5,
    parameter int W = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   xform_i,
    input  logic         cplx_i,
    output logic         valid_o,
    output logic [W-1:0] row_o,
    output logic [W-1:0] col_o,
    output logic [W-1:0] idx_o,
    output logic         side_valid_o,
    output logic [W-1:0] side_idx_o,
    output logic         x_en_o,
    output logic         y_en_o,
    output logic         y_zero_o,
    output logic         im_rd_o,
    output logic         mode_on_o,
    output logic         done_o
);
    localparam logic [W-1:0] LAST = W'(N - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        phase_e       phase;
        xform_e       xf;
        logic         cplx;
        logic [W-1:0] k;
        logic [W-1:0] n;
        logic [W-1:0] p;
    } seq_t;

    seq_t s_d, s_q;
    logic [W-1:0] p_next;
    logic [W-1:0] run_idx;
    logic [W-1:0] side_idx;

    // running (n*k) mod N: add k each column step
    xseq_modstep #(.N(N), .W(W)) u_step (
        .acc_i (s_q.p),
        .inc_i (s_q.k),
        .sum_o (p_next)
    );

    xseq_idxmap #(.N(N), .W(W)) u_map_run (
        .xf_i  (s_q.xf),
        .p_i   (s_q.p),
        .idx_o (run_idx)
    );

    xseq_idxmap #(.N(N), .W(W)) u_map_side (
        .xf_i  (s_q.xf),
        .p_i   ('0),
        .idx_o (side_idx)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_SIDE;
                    s_d.xf    = xform_e'(xform_i);
                    s_d.cplx  = cplx_i;
                    s_d.k     = ONE;
                    s_d.n     = ONE;
                    s_d.p     = ONE;
                end
            end
            PH_SIDE: s_d.phase = PH_RUN;
            PH_RUN: begin
                if (s_q.n == LAST) begin
                    if (s_q.k == LAST) begin
                        s_d.phase = PH_IDLE;
                    end else begin
                        s_d.k = s_q.k + ONE;
                        s_d.n = ONE;
                        s_d.p = s_q.k + ONE;
                    end
                end else begin
                    s_d.n = s_q.n + ONE;
                    s_d.p = p_next;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, xf: XF_DFT, cplx: 1'b0,
                     k: '0, n: '0, p: '0};
        end else begin
            s_q <= s_d;
        end
    end

    logic run, is_dft;

    always_comb begin
        run          = (s_q.phase == PH_RUN);
        is_dft       = (s_q.xf == XF_DFT);
        valid_o      = run;
        row_o        = s_q.k;
        col_o        = s_q.n;
        idx_o        = run_idx;
        side_valid_o = (s_q.phase == PH_SIDE);
        side_idx_o   = side_idx;
        x_en_o       = run;
        mode_on_o    = run && (s_q.xf == XF_DHT);
        y_en_o       = run && ((s_q.xf == XF_DHT) || (is_dft && s_q.cplx));
        y_zero_o     = run && is_dft && !s_q.cplx;
        im_rd_o      = run && is_dft && s_q.cplx;
        done_o       = run && (s_q.k == LAST) && (s_q.n == LAST);
    end
endmodule

// File: rtl/xseq_chk.sv
module xseq_chk #(
    parameter int N = 5,
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_o,
    input logic [W-1:0] row_o,
    input logic [W-1:0] col_o,
    input logic [W-1:0] idx_o,
    input logic         side_valid_o,
    input logic         x_en_o,
    input logic         y_en_o,
    input logic         y_zero_o,
    input logic         im_rd_o,
    input logic         mode_on_o,
    input logic         done_o
);
    localparam logic [W-1:0] LAST = W'(N - 1);

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !x_en_o && !y_en_o && !y_zero_o && !im_rd_o && !mode_on_o && !done_o);

    p_side_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        side_valid_o |=> valid_o && row_o == W'(1) && col_o == W'(1));

    p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && col_o != LAST |=> valid_o && col_o == $past(col_o) + W'(1) && row_o == $past(row_o));

    p_row_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && col_o == LAST && row_o != LAST |=> valid_o && col_o == W'(1) && row_o == $past(row_o) + W'(1));

    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> idx_o != '0 && idx_o <= W'(N));

    p_dht_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_on_o |-> y_en_o && x_en_o && !y_zero_o);

    p_y_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({y_en_o, y_zero_o}));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !valid_o && !side_valid_o);
endmodule

bind xform_seq_top xseq_chk #(.N(N), .W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_o      (valid_o),
    .row_o        (row_o),
    .col_o        (col_o),
    .idx_o        (idx_o),
    .side_valid_o (side_valid_o),
    .x_en_o       (x_en_o),
    .y_en_o       (y_en_o),
    .y_zero_o     (y_zero_o),
    .im_rd_o      (im_rd_o),
    .mode_on_o    (mode_on_o),
    .done_o       (done_o)
);

// File: tb/xform_seq_top_tb.sv
`timescale 1ns/1ps
module xform_seq_top_tb;
    localparam int N = 5;
    localparam int W = $clog2(N + 1);
    localparam int NCASE = 6;
    // {sel[1:0], cplx, exp_mode_on, exp_y_en, exp_y_zero, exp_im_rd}
    localparam logic [6:0] VEC [NCASE] = '{
        7'b00_0_0010,   // real Fourier  (R9)
        7'b00_1_0101,   // complex Fourier (R9)
        7'b01_0_1100,   // Hartley (R7)
        7'b01_1_1100,   // Hartley, cplx ignored (R7)
        7'b10_1_0000,   // cosine, cplx ignored (R8)
        7'b11_0_0000    // sine (R8)
    };

    logic clk = 0, rst_n = 0, start_i = 0, cplx_i = 0;
    logic [1:0] xform_i = 0;
    logic valid_o, side_valid_o, x_en_o, y_en_o, y_zero_o, im_rd_o, mode_on_o, done_o;
    logic [W-1:0] row_o, col_o, idx_o, side_idx_o;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xform_seq_top #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .xform_i(xform_i), .cplx_i(cplx_i),
        .valid_o(valid_o), .row_o(row_o), .col_o(col_o), .idx_o(idx_o),
        .side_valid_o(side_valid_o), .side_idx_o(side_idx_o),
        .x_en_o(x_en_o), .y_en_o(y_en_o), .y_zero_o(y_zero_o), .im_rd_o(im_rd_o),
        .mode_on_o(mode_on_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_idx(input int sel, input int k, input int n);
        int p = (k * n) % N;
        int f = (p <= (N - 1) / 2) ? 2 * p : 2 * N - 2 * p - 1;
        if (sel == 2) return f;
        if (sel == 3) return f + 1;
        return p;
    endfunction

    task automatic quiet(input string req);
        chk(!valid_o && !side_valid_o && !done_o && !x_en_o && !y_en_o && !y_zero_o
            && !im_rd_o && !mode_on_o, req,
            {valid_o, side_valid_o, done_o, x_en_o, y_en_o, y_zero_o, im_rd_o, mode_on_o}, 0);
    endtask

    // poke: raise start with another transform in the middle of the sweep (R11)
    task automatic run_case(input logic [6:0] v, input bit poke);
        int sel = int'(v[6:5]);
        start_i = 1; xform_i = v[6:5]; cplx_i = v[4];
        @(negedge clk);
        start_i = 0; xform_i = ~v[6:5]; cplx_i = ~v[4];
        chk(side_valid_o && !valid_o, "R2 side", int'(side_valid_o), 1);
        chk(int'(side_idx_o) == (sel == 3 ? 1 : 0), "R2 side_idx", int'(side_idx_o), sel == 3 ? 1 : 0);
        for (int k = 1; k < N; k++) begin
            for (int n = 1; n < N; n++) begin
                @(negedge clk);
                start_i = poke && (k == 2) && (n == 1);
                chk(valid_o && int'(row_o) == k && int'(col_o) == n, "R3 order",
                    int'(row_o) * 16 + int'(col_o), k * 16 + n);
                chk(int'(idx_o) == exp_idx(sel, k, n),
                    sel == 2 ? "R5 cosine idx" : (sel == 3 ? "R6 sine idx" : "R4 perm idx"),
                    int'(idx_o), exp_idx(sel, k, n));
                chk({mode_on_o, y_en_o, y_zero_o, im_rd_o, x_en_o} == {v[3:0], 1'b1},
                    sel == 1 ? "R7 flags" : (sel >= 2 ? "R8 flags" : "R9 flags"),
                    int'({mode_on_o, y_en_o, y_zero_o, im_rd_o, x_en_o}), int'({v[3:0], 1'b1}));
                if (poke) chk(mode_on_o == v[3], "R11 latched", int'(mode_on_o), int'(v[3]));
                chk(done_o == (k == N - 1 && n == N - 1), "R10 done", int'(done_o),
                    int'(k == N - 1 && n == N - 1));
            end
        end
        start_i = 0;
        @(negedge clk);
        quiet("R10 idle after done");
        chk(!side_valid_o, "R11 no restart", int'(side_valid_o), 0);
    endtask

    initial begin
        #1;
        quiet("R1 reset");
        @(negedge clk); @(negedge clk);
        quiet("R1 reset held");
        rst_n = 1;
        @(negedge clk);
        quiet("R1 idle");
        for (int i = 0; i < NCASE; i++) run_case(VEC[i], 1'b0);
        run_case(7'b10_0_0000, 1'b1);   // cosine, poked with start mid-sweep
        run_case(7'b00_1_0101, 1'b1);   // complex Fourier, poked
        @(negedge clk);
        quiet("R1 idle end");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule